// File: doc/BRIEF.md
# PCM Timeslot Transmit Router

This block takes a framed serial PCM stream and distributes it, one timeslot at a time, to up to three HDSL transmit channel queues. A bit-enable input paces the stream. A frame sync pulse marks the first bit of a frame. A small table, written through an address/data/write-enable port, holds one entry for each position in the frame. The framing bit, when the frame has one, gets an entry of its own. Each entry names the destination channels as a bit mask, which may be empty or hold several channels. It also names where the data comes from: the PCM input, an auxiliary insert input, a test-pattern bit input, or a replay of the byte built for the previous timeslot.

Completed bytes leave on a shared data bus with one write strobe per channel, so one timeslot can be copied to several queues in the same cycle. Two same-cycle strobes go to neighbouring logic. One advances an external pattern generator during pattern-sourced bits. The other marks the bits on which external logic must drive insert data, one timeslot ahead of the entry that consumes that data. An asynchronous mode bypasses the framing: it packs the whole PCM stream into bytes for a fixed channel mask.

The default frame is 24 eight-bit timeslots plus one framing bit. Clearing the framing-bit parameter and setting 32 timeslots gives the other common frame.

Top module: `pcm_ts_tx_router`

## Requirements
- R1: During reset and on the first cycle after reset, ch_wr is 0, ch_fbit is 0, and prbs_en and ins_mark are 0 while bit_en is low.
- R2: A table write sets entry cfg_addr from cfg_data. Bits 4:3 of cfg_data give the source: 0 = PCM input, 1 = insert input, 2 = pattern input, 3 = previous timeslot. Bits 2:0 give the channel mask, where bit i selects channel i. With a framing bit present, entry 0 is the framing bit and entry n is timeslot n-1.
- R3: A bit is consumed only in a cycle with bit_en high. A bit with fsync high is bit 0 of entry 0. After the last entry, the position wraps to entry 0 without needing fsync.
- R4: One cycle after the bit_en of the last bit of a timeslot entry, ch_wr equals the entry's mask for one cycle and ch_data carries the byte, with the first bit received in bit 7. An entry with mask 0 produces no strobe.
- R5: The framing-bit entry is one bit long. Its write carries the bit in ch_data bit 0, zeros in the other bits, and ch_fbit high. ch_fbit is never high without a strobe.
- R6: For a pattern-sourced entry, prbs_in supplies the data. prbs_en is high in exactly the bit_en cycles of pattern-sourced entries in framed mode, and only then.
- R7: ins_in is sampled on every bit_en. For an insert-sourced timeslot, the byte is the last eight ins_in bits sampled before the slot's first bit, oldest in bit 7. An insert-sourced framing bit takes the most recent ins_in bit.
- R8: ins_mark is high in each bit_en cycle of an entry whose following entry (wrapping from the last entry to entry 0) is insert-sourced, in framed mode.
- R9: A previous-sourced timeslot repeats the byte built for the most recent non-framing timeslot, whatever that timeslot's mask was. A previous-sourced framing bit takes bit 0 of that byte. After reset, that byte is 0.
- R10: An entry is read at the first bit of its timeslot. A table write during a timeslot takes effect at that entry's next occurrence.
- R11: While async_mode is high, the table, the framing and fsync are ignored. Each eight pcm_in bits, counted from the first bit after async_mode rises, are written as one byte (first bit in bit 7) to async_mask, with ch_fbit low. prbs_en and ins_mark stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One PCM bit is present this cycle |
| fsync | input | 1 | The current bit is the first bit of a frame |
| pcm_in | input | 1 | Serial PCM data |
| ins_in | input | 1 | Serial auxiliary insert data |
| prbs_in | input | 1 | Current bit of the external test pattern generator |
| async_mode | input | 1 | Pass the whole stream, ignoring framing |
| async_mask | input | 3 | Destination channels in asynchronous mode |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | $clog2(NUM_SLOTS+HAS_FBIT) | Table entry index |
| cfg_data | input | 5 | Entry: source in bits 4:3, mask in bits 2:0 |
| ch_wr | output | 3 | Per-channel write strobes |
| ch_data | output | SLOT_W | Byte written to the strobed channels |
| ch_fbit | output | 1 | The write carries a framing bit |
| ins_mark | output | 1 | Drive insert data on this bit |
| prbs_en | output | 1 | Advance the pattern generator on this bit |

## Verification
The hardest case to reach from the ports is a table write that lands in the middle of the very timeslot it reconfigures. The stimulus reaches it by raising cfg_we on the fourth bit of that slot while the stream keeps running. The frame then continues past the write, so the old mask must hold for the current pass and the new mask must apply on the next frame. Almost as awkward are the replay and insert sources across the framing bit and the frame wrap. For these, two frames run back to back with fsync only on the first, irregular idle cycles fall between bits, and previous-sourced and insert-sourced entries are placed right after the framing entry and right after one another.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int CH_N = 3;

  typedef enum logic [1:0] {
    SRC_PCM  = 2'd0,
    SRC_INS  = 2'd1,
    SRC_PRBS = 2'd2,
    SRC_PREV = 2'd3
  } src_e;

  typedef struct packed {
    src_e            src;
    logic [CH_N-1:0] mask;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);
endpackage

// File: rtl/rt_route_tbl.sv
module rt_route_tbl #(
  parameter int DEPTH = 25,
  parameter int AW    = 5
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  rt_pkg::ent_t        wr_ent,
  input  logic [AW-1:0]       rd_addr,
  output rt_pkg::ent_t        rd_ent,
  input  logic [AW-1:0]       nx_addr,
  output rt_pkg::src_e        nx_src
);
  rt_pkg::ent_t mem [DEPTH];

  // single write port, two asynchronous read ports (distributed RAM)
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < DEPTH)) begin
      mem[wr_addr] <= wr_ent;
    end
  end

  assign rd_ent = mem[rd_addr];
  assign nx_src = mem[nx_addr].src;
endmodule

// File: rtl/rt_frame_pos.sv
module rt_frame_pos #(
  parameter int NUM_ENT  = 25,
  parameter int HAS_FBIT = 1,
  parameter int SLOT_W   = 8,
  parameter int EW       = 5,
  parameter int BW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          fsync,
  input  logic          async_mode,
  output logic [EW-1:0] pos_ent,
  output logic [EW-1:0] nxt_ent,
  output logic [BW-1:0] pos_bit,
  output logic          first,
  output logic          last,
  output logic          is_f
);
  localparam logic [EW-1:0] LAST_ENT = EW'(NUM_ENT - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_W - 1);

  logic [EW-1:0] ent_q;
  logic [BW-1:0] bit_q;
  logic          resync;

  assign resync  = fsync && !async_mode;
  assign pos_ent = resync ? '0 : ent_q;
  assign pos_bit = resync ? '0 : bit_q;
  assign is_f    = (HAS_FBIT != 0) && (pos_ent == '0);
  assign first   = (pos_bit == '0);
  assign last    = is_f || (pos_bit == LAST_BIT);
  assign nxt_ent = (pos_ent == LAST_ENT) ? '0 : pos_ent + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q <= '0;
      bit_q <= '0;
    end else if (bit_en) begin
      if (last) begin
        bit_q <= '0;
        ent_q <= nxt_ent;
      end else begin
        bit_q <= pos_bit + 1'b1;
        ent_q <= pos_ent;
      end
    end
  end
endmodule

// File: rtl/rt_bit_asm.sv
module rt_bit_asm #(
  parameter int SLOT_W = 8,
  parameter int BW     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_en,
  input  logic                    async_mode,
  input  logic [rt_pkg::CH_N-1:0] async_mask,
  input  logic                    pcm_in,
  input  logic                    ins_in,
  input  logic                    prbs_in,
  input  logic                    first,
  input  logic                    last,
  input  logic                    is_f,
  input  logic [BW-1:0]           pos_bit,
  input  rt_pkg::ent_t            tbl_cur,
  input  rt_pkg::src_e            tbl_nsrc,
  output logic [rt_pkg::CH_N-1:0] ch_wr,
  output logic [SLOT_W-1:0]       ch_data,
  output logic                    ch_fbit,
  output logic                    prbs_en,
  output logic                    ins_mark
);
  import rt_pkg::*;

  localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_W - 1);

  ent_t              cur_q;
  src_e              nsrc_q;
  logic [SLOT_W-1:0] ins_sr, ins_lat, prev_byte, prev_lat;
  logic [SLOT_W-2:0] asm_sr;
  logic [BW-1:0]     acnt;

  ent_t              ent;
  src_e              nsrc;
  logic [SLOT_W-1:0] ins_b, prv_b, byte_w;
  logic [BW-1:0]     idx;
  logic              dbit;

  // entry and replay sources are taken from the table at bit 0, held after
  assign ent   = first ? tbl_cur   : cur_q;
  assign nsrc  = first ? tbl_nsrc  : nsrc_q;
  assign ins_b = first ? ins_sr    : ins_lat;
  assign prv_b = first ? prev_byte : prev_lat;
  assign idx   = LAST_BIT - pos_bit;

  always_comb begin
    unique case (ent.src)
      SRC_PCM:  dbit = pcm_in;
      SRC_INS:  dbit = is_f ? ins_b[0] : ins_b[idx];
      SRC_PRBS: dbit = prbs_in;
      SRC_PREV: dbit = is_f ? prv_b[0] : prv_b[idx];
      default:  dbit = pcm_in;
    endcase
  end

  assign byte_w   = {asm_sr, dbit};
  assign prbs_en  = bit_en && !async_mode && (ent.src == SRC_PRBS);
  assign ins_mark = bit_en && !async_mode && (nsrc == SRC_INS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q     <= '0;
      nsrc_q    <= SRC_PCM;
      ins_sr    <= '0;
      ins_lat   <= '0;
      prev_byte <= '0;
      prev_lat  <= '0;
      asm_sr    <= '0;
      acnt      <= '0;
      ch_wr     <= '0;
      ch_data   <= '0;
      ch_fbit   <= 1'b0;
    end else begin
      ch_wr   <= '0;
      ch_fbit <= 1'b0;
      if (!async_mode) begin
        acnt <= '0;
      end
      if (bit_en) begin
        ins_sr <= {ins_sr[SLOT_W-2:0], ins_in};
        asm_sr <= {asm_sr[SLOT_W-3:0], (async_mode ? pcm_in : dbit)};
        if (async_mode) begin
          if (acnt == LAST_BIT) begin
            acnt    <= '0;
            ch_wr   <= async_mask;
            ch_data <= {asm_sr, pcm_in};
          end else begin
            acnt <= acnt + 1'b1;
          end
        end else begin
          if (first) begin
            cur_q    <= tbl_cur;
            nsrc_q   <= tbl_nsrc;
            ins_lat  <= ins_sr;
            prev_lat <= prev_byte;
          end
          if (last) begin
            ch_wr <= ent.mask;
            if (is_f) begin
              ch_data <= {{(SLOT_W-1){1'b0}}, dbit};
              ch_fbit <= (ent.mask != '0);
            end else begin
              ch_data   <= byte_w;
              prev_byte <= byte_w;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_ts_tx_router.sv
module pcm_ts_tx_router #(
  parameter int NUM_SLOTS = 24,
  parameter int HAS_FBIT  = 1,
  parameter int SLOT_W    = 8
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      bit_en,
  input  logic                                      fsync,
  input  logic                                      pcm_in,
  input  logic                                      ins_in,
  input  logic                                      prbs_in,
  input  logic                                      async_mode,
  input  logic [rt_pkg::CH_N-1:0]                   async_mask,
  input  logic                                      cfg_we,
  input  logic [$clog2(NUM_SLOTS+HAS_FBIT)-1:0]     cfg_addr,
  input  logic [rt_pkg::ENT_W-1:0]                  cfg_data,
  output logic [rt_pkg::CH_N-1:0]                   ch_wr,
  output logic [SLOT_W-1:0]                         ch_data,
  output logic                                      ch_fbit,
  output logic                                      ins_mark,
  output logic                                      prbs_en
);
  localparam int NUM_ENT = NUM_SLOTS + HAS_FBIT;
  localparam int EW      = $clog2(NUM_ENT);
  localparam int BW      = $clog2(SLOT_W);

  logic [EW-1:0] pos_ent, nxt_ent;
  logic [BW-1:0] pos_bit;
  logic          first, last, is_f;
  rt_pkg::ent_t  cfg_ent, tbl_cur;
  rt_pkg::src_e  tbl_nsrc;

  assign cfg_ent = rt_pkg::ent_t'(cfg_data);

  rt_frame_pos #(
    .NUM_ENT (NUM_ENT),
    .HAS_FBIT(HAS_FBIT),
    .SLOT_W  (SLOT_W),
    .EW      (EW),
    .BW      (BW)
  ) pos_i (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .fsync     (fsync),
    .async_mode(async_mode),
    .pos_ent   (pos_ent),
    .nxt_ent   (nxt_ent),
    .pos_bit   (pos_bit),
    .first     (first),
    .last      (last),
    .is_f      (is_f)
  );

  rt_route_tbl #(
    .DEPTH(NUM_ENT),
    .AW   (EW)
  ) tbl_i (
    .clk    (clk),
    .wr_en  (cfg_we),
    .wr_addr(cfg_addr),
    .wr_ent (cfg_ent),
    .rd_addr(pos_ent),
    .rd_ent (tbl_cur),
    .nx_addr(nxt_ent),
    .nx_src (tbl_nsrc)
  );

  rt_bit_asm #(
    .SLOT_W(SLOT_W),
    .BW    (BW)
  ) asm_i (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .async_mode(async_mode),
    .async_mask(async_mask),
    .pcm_in    (pcm_in),
    .ins_in    (ins_in),
    .prbs_in   (prbs_in),
    .first     (first),
    .last      (last),
    .is_f      (is_f),
    .pos_bit   (pos_bit),
    .tbl_cur   (tbl_cur),
    .tbl_nsrc  (tbl_nsrc),
    .ch_wr     (ch_wr),
    .ch_data   (ch_data),
    .ch_fbit   (ch_fbit),
    .prbs_en   (prbs_en),
    .ins_mark  (ins_mark)
  );
endmodule

// File: rtl/rt_router_chk.sv
module rt_router_chk (
  input logic                    clk,
  input logic                    rst,
  input logic                    bit_en,
  input logic                    async_mode,
  input logic [rt_pkg::CH_N-1:0] async_mask,
  input logic [rt_pkg::CH_N-1:0] ch_wr,
  input logic                    ch_fbit,
  input logic                    prbs_en,
  input logic                    ins_mark
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ch_wr == '0 && !ch_fbit));

  a_r4_wr_needs_bit: assert property (@(posedge clk) disable iff (rst)
    (ch_wr != '0) |-> $past(bit_en));

  a_r5_fbit_with_wr: assert property (@(posedge clk) disable iff (rst)
    ch_fbit |-> (ch_wr != '0));

  a_r6_prbs_en_framed: assert property (@(posedge clk) disable iff (rst)
    prbs_en |-> (bit_en && !async_mode));

  a_r8_mark_framed: assert property (@(posedge clk) disable iff (rst)
    ins_mark |-> (bit_en && !async_mode));

  a_r11_async_dest: assert property (@(posedge clk) disable iff (rst)
    ((ch_wr != '0) && $past(async_mode)) |-> (ch_wr == $past(async_mask) && !ch_fbit));
endmodule

bind pcm_ts_tx_router rt_router_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .bit_en    (bit_en),
  .async_mode(async_mode),
  .async_mask(async_mask),
  .ch_wr     (ch_wr),
  .ch_fbit   (ch_fbit),
  .prbs_en   (prbs_en),
  .ins_mark  (ins_mark)
);

// File: tb/pcm_ts_tx_router_tb_top.sv
module pcm_ts_tx_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0, fsync = 1'b0, pcm_in = 1'b0, ins_in = 1'b0, prbs_in = 1'b0;
  logic       async_mode = 1'b0;
  logic [2:0] async_mask = 3'b000;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [4:0] cfg_data = '0;
  logic [2:0] ch_wr;
  logic [7:0] ch_data;
  logic       ch_fbit, ins_mark, prbs_en;

  int errs = 0, checks = 0, strobe_bad = 0;
  bit done = 1'b0;

  logic [4:0]  tbl_m [NENT];
  logic [11:0] exp_q[$], got_q[$];
  int          mid_at = -1;
  logic [4:0]  mid_addr = '0, mid_data = '0;

  int          m_ent = 0, m_bit = 0, m_acnt = 0;
  logic [4:0]  m_cur = '0;
  logic [1:0]  m_nsrc = '0;
  logic [7:0]  m_ins_hist = '0, m_ins_lat = '0, m_prev = '0, m_prev_lat = '0, m_sr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_ts_tx_router dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .fsync(fsync), .pcm_in(pcm_in),
    .ins_in(ins_in), .prbs_in(prbs_in), .async_mode(async_mode), .async_mask(async_mask),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .ch_wr(ch_wr),
    .ch_data(ch_data), .ch_fbit(ch_fbit), .ins_mark(ins_mark), .prbs_en(prbs_en)
  );

  always @(negedge clk) begin
    if (!rst && ch_wr != 3'b000) got_q.push_back({ch_wr, ch_data, ch_fbit});
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic cfg_write(input int a, input logic [4:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_data = d;
    tbl_m[a] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // expected behaviour per bit, derived from R3..R11
  task automatic model_step();
    logic d, isf, exp_p, exp_m;
    exp_p = 1'b0; exp_m = 1'b0;
    if (async_mode) begin
      m_sr = {m_sr[6:0], pcm_in};
      m_acnt++;
      if (m_acnt == 8) begin
        m_acnt = 0;
        if (async_mask != 3'b000) exp_q.push_back({async_mask, m_sr, 1'b0});
      end
    end else begin
      if (fsync) begin m_ent = 0; m_bit = 0; end
      if (m_bit == 0) begin
        m_cur = tbl_m[m_ent];
        m_nsrc = tbl_m[(m_ent + 1) % NENT][4:3];
        m_ins_lat = m_ins_hist;
        m_prev_lat = m_prev;
      end
      isf = (m_ent == 0);
      case (m_cur[4:3])
        2'd0: d = pcm_in;
        2'd1: d = isf ? m_ins_lat[0] : m_ins_lat[7 - m_bit];
        2'd2: d = prbs_in;
        default: d = isf ? m_prev_lat[0] : m_prev_lat[7 - m_bit];
      endcase
      exp_p = (m_cur[4:3] == 2'd2);
      exp_m = (m_nsrc == 2'd1);
      if (isf) begin
        if (m_cur[2:0] != 3'b000) exp_q.push_back({m_cur[2:0], 7'b0, d, 1'b1});
        m_ent = 1; m_bit = 0;
      end else begin
        m_sr = {m_sr[6:0], d};
        if (m_bit == 7) begin
          if (m_cur[2:0] != 3'b000) exp_q.push_back({m_cur[2:0], m_sr, 1'b0});
          m_prev = m_sr;
          m_bit = 0;
          m_ent = (m_ent + 1) % NENT;
        end else begin
          m_bit++;
        end
      end
    end
    m_ins_hist = {m_ins_hist[6:0], ins_in};
    if (prbs_en !== exp_p || ins_mark !== exp_m) strobe_bad++;
  endtask

  task automatic run_bits(input int n, input bit fs_first, input bit gaps);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom() % 4 == 0)) @(negedge clk);
      pcm_in = 1'($urandom()); ins_in = 1'($urandom()); prbs_in = 1'($urandom());
      fsync = fs_first && (i == 0);
      bit_en = 1'b1;
      if (i == mid_at) begin cfg_we = 1'b1; cfg_addr = mid_addr; cfg_data = mid_data; end
      #1;
      model_step();
      if (i == mid_at) tbl_m[mid_addr] = mid_data;
      @(negedge clk);
      bit_en = 1'b0; fsync = 1'b0; cfg_we = 1'b0;
    end
  endtask

  task automatic compare(input string req);
    int n;
    repeat (3) @(negedge clk);
    chk(got_q.size() == exp_q.size(), {req, " write count"}, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(got_q[i] == exp_q[i], {req, " write {mask,data,fbit}"}, got_q[i], exp_q[i]);
    chk(strobe_bad == 0, {req, " R6/R8 strobe mismatches"}, strobe_bad, 0);
    got_q.delete(); exp_q.delete(); strobe_bad = 0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(ch_wr == 3'b000, "R1 ch_wr in reset", ch_wr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ch_wr == 3'b000, "R1 ch_wr after reset", ch_wr, 0);
    chk(ch_fbit == 1'b0, "R1 ch_fbit after reset", ch_fbit, 0);
    chk(prbs_en == 1'b0 && ins_mark == 1'b0, "R1 strobes idle", {prbs_en, ins_mark}, 0);
  endtask

  // R2 R4 R5: plain PCM routing with every mask value
  task automatic t_route_pcm();
    for (int e = 0; e < NENT; e++) cfg_write(e, {2'b00, 3'(e % 8)});
    run_bits(193, 1'b1, 1'b1);
    compare("R4 R5 R2 pcm routing");
  endtask

  // R6 R7 R8 R9 with a wrapped second frame (R3)
  task automatic t_sources();
    for (int e = 0; e < NENT; e++)
      cfg_write(e, {2'(e % 4), (e % 5 == 0) ? 3'b010 : 3'b111});
    cfg_write(0, {2'b01, 3'b111});
    run_bits(386, 1'b1, 1'b1);
    compare("R7 R9 R6 sources");
  endtask

  task automatic t_realign();
    run_bits(70, 1'b1, 1'b0);
    run_bits(193, 1'b1, 1'b1);
    compare("R3 fsync realign");
  endtask

  task automatic t_midwrite();
    for (int e = 0; e < NENT; e++) cfg_write(e, {2'b00, 3'b001});
    cfg_write(0, {2'b11, 3'b011});
    mid_at = 36; mid_addr = 5'd5; mid_data = {2'b00, 3'b110};
    run_bits(386, 1'b1, 1'b0);
    mid_at = -1;
    compare("R10 mid-slot table write");
  endtask

  task automatic t_async();
    @(negedge clk);
    async_mode = 1'b1; async_mask = 3'b101; m_acnt = 0;
    run_bits(40, 1'b1, 1'b1);
    compare("R11 async pass-through");
    @(negedge clk);
    async_mode = 1'b0;
  endtask

  initial begin
    for (int e = 0; e < NENT; e++) tbl_m[e] = '0;
    t_reset();
    t_route_pcm();
    t_sources();
    t_realign();
    t_midwrite();
    t_async();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule